// File: doc/BRIEF.md
# Split Program Counter With Deferred Page Carry

This block holds a program counter as two separate byte registers, a low byte and a high byte, which together form a 16-bit address. Each byte is controlled by its own 4-bit gate command. The command has two ports. The front port connects the byte to the internal 8-bit data bus. The back port connects the byte to its half of the 16-bit address bus. All command bits are active low.

The low byte advances when an active-low step strobe is given and both of its back-port enables are asserted. When the low byte wraps, the carry is captured in a register. On the following cycle, the high byte can advance if its own back-port enables are asserted at that time. While that carry is pending, the low byte cannot step.

Jumps and vector fetches load the bytes from the data bus through front-port writes. The low byte is loaded first and the high byte in a later cycle.

Top module: `pc_split_counter`

## Requirements
- R1: A synchronous active-high reset clears both bytes, the address output, the data output and data_en, and sets page_carry_n to 1 (no carry pending).
- R2: Each gate command is decoded as bit 3 = front output enable, bit 2 = front write enable, bit 1 = back output enable, bit 0 = back write enable, each active when 0.
- R3: The low byte steps by one on a clock edge only when inc_n is 0 and bits 1 and 0 of lo_cmd are both 0. With inc_n at 1, or with either back bit at 1, the low byte is unchanged.
- R4: A front write (cmd bit 2 = 0) loads the byte from data_i. A front write takes priority over a step in the same cycle, and a load never produces a carry.
- R5: A step of the low byte from 0xFF to 0x00 drives page_carry_n to 0 for exactly the one cycle after that edge.
- R6: During a cycle with page_carry_n at 0 and bits 1 and 0 of hi_cmd both 0, the high byte steps by one. It wraps from 0xFF to 0x00 and raises no further carry.
- R7: While page_carry_n is 0, the low byte does not step, even if inc_n and its back enables are all asserted.
- R8: Outputs data_en and data_o are registered. They reflect the front output enables of the previous cycle and the byte values before that edge. The low byte wins over the high byte if both are enabled. When neither is enabled, data_en is 0 and data_o is 0.
- R9: Each half of addr_o (low byte in bits 7:0, high byte in bits 15:8) is registered. It takes the byte's value from before the edge when that byte's back output enable is 0, and otherwise holds its last value.
- R10: A vector or jump load writes the low byte in one cycle and the high byte in the following cycle. The full 16-bit value then appears on addr_o.
- R11: If the high byte's back enables are not both 0 during the pending-carry cycle, the carry is dropped and the high byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_cmd | input | 4 | Low-byte gate command, active low |
| hi_cmd | input | 4 | High-byte gate command, active low |
| inc_n | input | 1 | Low-byte step strobe, active low |
| data_i | input | 8 | Data bus value for front-port loads |
| data_o | output | 8 | Registered front-port byte |
| data_en | output | 1 | Registered front-port drive enable |
| addr_o | output | 16 | Registered address, high byte in bits 15:8 |
| page_carry_n | output | 1 | Pending high-byte step request, active low |

## Verification
The hardest state to reach is the pending-carry cycle. Both bytes must first be preloaded through front writes, and the low byte must then be stepped from 0xFF. Only after that can the high-byte gating and the low-byte lockout be tested in the single cycle that follows. Directed tasks build this sequence for three cases:
- with the high byte at 0xFF, so the high byte wraps;
- with the high byte at an ordinary value, while a low step is also requested;
- with the high gates left closed, so the carry is dropped.

The byte contents are then read back through a back-port read onto addr_o.

// File: rtl/pc_split_pkg.sv
package pc_split_pkg;

  // One byte's gate command, MSB first: front oe, front we, back oe, back we.
  typedef struct packed {
    logic fr_oe_n;
    logic fr_we_n;
    logic bk_oe_n;
    logic bk_we_n;
  } gate_cmd_t;

  // Both back-port enables are asserted (the byte may step).
  function automatic logic back_step(input gate_cmd_t c);
    return !c.bk_oe_n && !c.bk_we_n;
  endfunction

endpackage

// File: rtl/pc_byte_reg.sv
module pc_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] ONE = W'(1);

  // A front-port load wins over a step in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (!load_n)
      q <= din;
    else if (step)
      q <= q + ONE;
  end

endmodule

// File: rtl/pc_carry_sync.sv
module pc_carry_sync (
  input  logic clk,
  input  logic rst,
  input  logic carry,
  output logic req_n
);

  // The carry becomes a request that lasts exactly one cycle.
  always_ff @(posedge clk) begin
    if (rst)
      req_n <= 1'b1;
    else
      req_n <= ~carry;
  end

endmodule

// File: rtl/pc_port_out.sv
module pc_port_out
  import pc_split_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  gate_cmd_t      lo_c,
  input  gate_cmd_t      hi_c,
  input  logic [W-1:0]   lo_q,
  input  logic [W-1:0]   hi_q,
  output logic [W-1:0]   dout,
  output logic           den,
  output logic [2*W-1:0] addr
);

  localparam int NB = 2;

  gate_cmd_t    cmd_a [NB];
  logic [W-1:0] val_a [NB];

  assign cmd_a[0] = lo_c;
  assign cmd_a[1] = hi_c;
  assign val_a[0] = lo_q;
  assign val_a[1] = hi_q;

  // One registered address half per byte.
  for (genvar b = 0; b < NB; b++) begin : g_half
    logic [W-1:0] half_r;

    always_ff @(posedge clk) begin
      if (rst)
        half_r <= '0;
      else if (!cmd_a[b].bk_oe_n)
        half_r <= val_a[b];
    end

    assign addr[b*W +: W] = half_r;
  end

  // Front port: the low byte has priority over the high byte.
  always_ff @(posedge clk) begin
    if (rst) begin
      den  <= 1'b0;
      dout <= '0;
    end else begin
      den <= !lo_c.fr_oe_n || !hi_c.fr_oe_n;
      if (!lo_c.fr_oe_n)
        dout <= lo_q;
      else if (!hi_c.fr_oe_n)
        dout <= hi_q;
      else
        dout <= '0;
    end
  end

endmodule

// File: rtl/pc_split_counter.sv
module pc_split_counter
  import pc_split_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     lo_cmd,
  input  logic [3:0]     hi_cmd,
  input  logic           inc_n,
  input  logic [W-1:0]   data_i,
  output logic [W-1:0]   data_o,
  output logic           data_en,
  output logic [2*W-1:0] addr_o,
  output logic           page_carry_n
);

  gate_cmd_t    lo_c, hi_c;
  logic         lo_step, hi_step, lo_wrap;
  logic [W-1:0] lo_q, hi_q;

  assign lo_c = gate_cmd_t'(lo_cmd);
  assign hi_c = gate_cmd_t'(hi_cmd);

  // The low byte is locked out while a page carry is pending.
  assign lo_step = !inc_n && back_step(lo_c) && page_carry_n;
  assign hi_step = !page_carry_n && back_step(hi_c);
  assign lo_wrap = lo_step && lo_c.fr_we_n && (&lo_q);

  pc_byte_reg #(.W(W)) i_lo (
    .clk(clk), .rst(rst), .load_n(lo_c.fr_we_n), .step(lo_step),
    .din(data_i), .q(lo_q)
  );

  pc_byte_reg #(.W(W)) i_hi (
    .clk(clk), .rst(rst), .load_n(hi_c.fr_we_n), .step(hi_step),
    .din(data_i), .q(hi_q)
  );

  pc_carry_sync i_carry (
    .clk(clk), .rst(rst), .carry(lo_wrap), .req_n(page_carry_n)
  );

  pc_port_out #(.W(W)) i_ports (
    .clk(clk), .rst(rst), .lo_c(lo_c), .hi_c(hi_c), .lo_q(lo_q), .hi_q(hi_q),
    .dout(data_o), .den(data_en), .addr(addr_o)
  );

endmodule

// File: rtl/pc_split_counter_chk.sv
module pc_split_counter_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [3:0]     lo_cmd,
  input logic [3:0]     hi_cmd,
  input logic           inc_n,
  input logic           page_carry_n,
  input logic           data_en,
  input logic [W-1:0]   lo_q,
  input logic [W-1:0]   hi_q,
  input logic [2*W-1:0] addr_o
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (lo_q == '0 && hi_q == '0 && page_carry_n && !data_en));

  assert_carry_single_R5: assert property (@(posedge clk) disable iff (rst)
    !page_carry_n |=> page_carry_n);

  assert_lo_lockout_R7: assert property (@(posedge clk) disable iff (rst)
    (!page_carry_n && lo_cmd[2] && !inc_n) |=> (lo_q == $past(lo_q)));

  assert_hi_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (hi_q != $past(hi_q)) |->
      ($past(!hi_cmd[2]) || $past(!page_carry_n && hi_cmd[1:0] == 2'b00)));

  assert_front_en_R8: assert property (@(posedge clk) disable iff (rst)
    data_en |-> $past(!lo_cmd[3] || !hi_cmd[3]));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $past(lo_cmd[1]) |-> (addr_o[W-1:0] == $past(addr_o[W-1:0])));

endmodule

bind pc_split_counter pc_split_counter_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .lo_cmd(lo_cmd), .hi_cmd(hi_cmd), .inc_n(inc_n),
  .page_carry_n(page_carry_n), .data_en(data_en), .lo_q(lo_q), .hi_q(hi_q),
  .addr_o(addr_o)
);

// File: tb/test_pc_split_counter.sv
`timescale 1ns/1ps
module test_pc_split_counter;

  localparam int W = 8;
  localparam logic [3:0] IDLE  = 4'hF;
  localparam logic [3:0] BSTEP = 4'b1100;
  localparam logic [3:0] BOE   = 4'b1101;
  localparam logic [3:0] FWE   = 4'b1011;
  localparam logic [3:0] FOE   = 4'b0111;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [3:0]     lo_cmd = IDLE, hi_cmd = IDLE;
  logic           inc_n = 1'b1;
  logic [W-1:0]   data_i = '0;
  logic [W-1:0]   data_o;
  logic           data_en;
  logic [2*W-1:0] addr_o;
  logic           page_carry_n;

  pc_split_counter #(.W(W)) i_pc_split_counter (
    .clk(clk), .rst(rst), .lo_cmd(lo_cmd), .hi_cmd(hi_cmd), .inc_n(inc_n),
    .data_i(data_i), .data_o(data_o), .data_en(data_en), .addr_o(addr_o),
    .page_carry_n(page_carry_n)
  );

  always #2 clk = ~clk;

  // Reference model, built from the requirements.
  logic [W-1:0] m_lo = '0, m_hi = '0, m_alo = '0, m_ahi = '0, m_dat = '0;
  logic         m_den = 1'b0, m_req_n = 1'b1;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic fire_lo, fire_hi, carry;
    if (rst) begin
      m_lo = '0; m_hi = '0; m_alo = '0; m_ahi = '0;
      m_dat = '0; m_den = 1'b0; m_req_n = 1'b1;
    end else begin
      fire_lo = !inc_n && lo_cmd[1:0] == 2'b00 && m_req_n;
      fire_hi = !m_req_n && hi_cmd[1:0] == 2'b00;
      carry   = lo_cmd[2] && fire_lo && (m_lo == 8'hFF);
      if (!lo_cmd[1]) m_alo = m_lo;
      if (!hi_cmd[1]) m_ahi = m_hi;
      m_den = !lo_cmd[3] || !hi_cmd[3];
      m_dat = !lo_cmd[3] ? m_lo : (!hi_cmd[3] ? m_hi : '0);
      if (!lo_cmd[2]) m_lo = data_i; else if (fire_lo) m_lo = m_lo + 8'd1;
      if (!hi_cmd[2]) m_hi = data_i; else if (fire_hi) m_hi = m_hi + 8'd1;
      m_req_n = !carry;
    end
  endtask

  // Drive at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic cyc(input string tag, input logic [3:0] lc, input logic [3:0] hc,
                     input logic inc, input logic [W-1:0] d);
    lo_cmd = lc; hi_cmd = hc; inc_n = inc; data_i = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "addr_o", 32'(addr_o), 32'({m_ahi, m_alo}));
    check(tag, "data_en", 32'(data_en), 32'(m_den));
    check(tag, "data_o", 32'(data_o), 32'(m_dat));
    check(tag, "page_carry_n", 32'(page_carry_n), 32'(m_req_n));
  endtask

  task automatic load_pair(input string tag, input logic [W-1:0] lo, input logic [W-1:0] hi);
    cyc(tag, FWE, IDLE, 1'b1, lo);
    cyc(tag, IDLE, FWE, 1'b1, hi);
  endtask

  task automatic view(input string tag);
    cyc(tag, BOE, BOE, 1'b1, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 5; i++) cyc("R1", IDLE, IDLE, 1'b1, '0);
    rst = 1'b0;
    cyc("R1", IDLE, IDLE, 1'b1, '0);
    check("R1", "addr_o after reset", 32'(addr_o), 32'h0);
    check("R1", "page_carry_n after reset", 32'(page_carry_n), 32'h1);
  endtask

  task automatic t_step();
    for (int i = 0; i < 3; i++) cyc("R3", BSTEP, IDLE, 1'b0, '0);
    cyc("R2", 4'b1110, IDLE, 1'b0, '0);
    cyc("R3", BSTEP, IDLE, 1'b1, '0);
    view("R3");
    check("R3", "low after three steps", 32'(addr_o[7:0]), 32'h03);
  endtask

  task automatic t_load();
    cyc("R4", 4'b1000, IDLE, 1'b0, 8'h34);
    view("R4");
    check("R4", "load beats step", 32'(addr_o[7:0]), 32'h34);
    check("R4", "no carry on load", 32'(page_carry_n), 32'h1);
  endtask

  task automatic t_vector();
    load_pair("R10", 8'hCD, 8'hAB);
    view("R10");
    check("R10", "vector address", 32'(addr_o), 32'hABCD);
  endtask

  task automatic t_carry();
    load_pair("R5", 8'hFF, 8'h12);
    cyc("R5", BSTEP, IDLE, 1'b0, '0);
    check("R5", "carry pending", 32'(page_carry_n), 32'h0);
    cyc("R7", BSTEP, BSTEP, 1'b0, '0);
    check("R5", "carry cleared", 32'(page_carry_n), 32'h1);
    view("R7");
    check("R7", "low locked, high stepped", 32'(addr_o), 32'h1300);
  endtask

  task automatic t_hiwrap();
    load_pair("R6", 8'hFF, 8'hFF);
    cyc("R6", BSTEP, IDLE, 1'b0, '0);
    cyc("R6", IDLE, BSTEP, 1'b1, '0);
    check("R6", "no carry from high", 32'(page_carry_n), 32'h1);
    view("R6");
    check("R6", "high wraps", 32'(addr_o), 32'h0000);
    check("R6", "still no carry", 32'(page_carry_n), 32'h1);
  endtask

  task automatic t_drop();
    load_pair("R11", 8'hFF, 8'h40);
    cyc("R11", BSTEP, IDLE, 1'b0, '0);
    cyc("R11", IDLE, IDLE, 1'b1, '0);
    view("R11");
    check("R11", "carry dropped", 32'(addr_o), 32'h4000);
  endtask

  task automatic t_front();
    load_pair("R8", 8'h5A, 8'hA5);
    cyc("R8", FOE, IDLE, 1'b1, '0);
    check("R8", "low on bus", 32'(data_o), 32'h5A);
    cyc("R8", FOE, FOE, 1'b1, '0);
    check("R8", "low has priority", 32'(data_o), 32'h5A);
    cyc("R8", IDLE, FOE, 1'b1, '0);
    check("R8", "high on bus", 32'(data_o), 32'hA5);
    cyc("R8", IDLE, IDLE, 1'b1, '0);
    check("R8", "bus released", 32'(data_en), 32'h0);
  endtask

  task automatic t_hold();
    view("R9");
    cyc("R9", FWE, IDLE, 1'b1, 8'h77);
    check("R9", "address held", 32'(addr_o[7:0]), 32'h5A);
    view("R9");
    check("R9", "address updated", 32'(addr_o[7:0]), 32'h77);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_step();
    t_load();
    t_vector();
    t_carry();
    t_hiwrap();
    t_drop();
    t_front();
    t_hold();
    report();
  end

endmodule